// File: doc/BRIEF.md
# Receive Message Buffer Store with Read Lock

This block holds a bank of receive slots for a CAN controller. Each slot keeps a status code, an identifier, a length field, eight data bytes and a 16-bit arrival timestamp, which is 16 bytes of payload per slot. Frames that have already passed acceptance filtering arrive on a single-cycle frame-valid strobe that names the destination slot. The block decides whether the frame is dropped, stored, or parked. When a slot is overwritten before software has looked at it, the block raises an overrun code.

Software reads through a one-word read port. Reading a slot's control word freezes that slot, so that the identifier and data words read afterwards belong to the same frame. While a slot is frozen, a frame aimed at it waits in a single staging register. The freeze ends when software reads the free-running timer, or when it reads the control word of a different slot. At that point the parked frame is written in. Each store sets a per-slot flag, and software clears the flag by writing a one to it.

Top module: `rx_buffer_mgr`

## Requirements
- R1: After reset every slot holds code 4'b0000 (inactive), all flags are 0, `rd_data` is 0, the timer is 0 and no slot is frozen.
- R2: A configuration write sets the code of slot `cfg_buf` to `cfg_code` (4'b0100 = empty, 4'b0000 = inactive) and clears that slot's read-since-store mark. A frame aimed at an inactive slot is discarded and sets no flag. If a configuration write and a store hit the same slot in the same cycle, the configuration wins and the store is dropped.
- R3: A frame aimed at an empty, unfrozen slot is stored in the cycle it is presented. The slot's code becomes 4'b0010 (full) and its flag is set.
- R4: A read with `rd_sel`=0 returns that slot's control word on `rd_data` one cycle later. From the following cycle the slot is frozen: its stored content does not change while the freeze lasts.
- R5: The freeze ends on a timer read (`rd_sel`=4) or on a control-word read of a different slot. Reads of identifier or data words, and repeated control-word reads of the frozen slot, leave the freeze in place.
- R6: A full slot whose control word was read after its last store takes a new frame and stays at 4'b0010.
- R7: A full or overrun slot that has not been read since its last store takes a new frame, and its code becomes 4'b0110 (overrun) with the new content.
- R8: A frame aimed at the frozen slot is held in the staging register and written in when the freeze ends. The code follows R6/R7. A second frame arriving while one is already staged replaces the staged frame, and the commit then writes code 4'b0110.
- R9: The timer advances by one every cycle and wraps at 16 bits. A stored frame carries the timer value of the cycle in which it was presented. A timer read returns that cycle's timer value in bits [15:0].
- R10: Writing ones on `flag_clr` with `flag_clr_we` clears those flags. A store in the same cycle sets its flag regardless of the clear.
- R11: The read words are as follows. Select 0 gives {4'b0, code[3:0], 4'b0, dlc[3:0], stamp[15:0]}. Select 1 gives {3'b0, id[28:0]}. Select 2 gives data[63:32]. Select 3 gives data[31:0]. Select 4 gives {16'b0, timer}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Slot code write strobe |
| cfg_buf | input | IDX_W | Slot addressed by the code write |
| cfg_code | input | 4 | Code to write |
| frm_valid | input | 1 | Incoming frame strobe |
| frm_buf | input | IDX_W | Destination slot of the frame |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Frame length code |
| frm_data | input | 64 | Frame payload |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 3 | Word select (see R11) |
| rd_buf | input | IDX_W | Slot to read |
| rd_data | output | 32 | Read word, valid one cycle after the strobe |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | NUM_BUF | Flags to clear, one bit per slot |
| flags | output | NUM_BUF | Per-slot store flags |
| timer | output | 16 | Free-running timer |

## Verification
The bench focuses on these cases:
- Overwriting a full slot before and after its control word is read. A design that ignores the read mark would report overrun for a slot that was read, or miss the overrun for one that was not.
- Parking frames at a frozen slot, one and then two of them. Releasing the freeze both by a timer read and by a control read of another slot. A design that releases on identifier or data reads, or drops the parked frame, would show a changed or empty slot at the wrong moment.
- A flag clear in the same cycle as a store, where the flag must stay set.
- Timer wrap-around.
- A long stretch of mixed traffic that collides configuration writes, freezes and frames, compared cycle by cycle against a behavioural model.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int TS_W   = 16;
    localparam int WORD_W = 32;

    typedef logic [3:0] code_t;

    localparam code_t CODE_INACTIVE = 4'b0000;
    localparam code_t CODE_EMPTY    = 4'b0100;
    localparam code_t CODE_FULL     = 4'b0010;
    localparam code_t CODE_OVERRUN  = 4'b0110;

    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_ID   = 3'd1,
        SEL_DHI  = 3'd2,
        SEL_DLO  = 3'd3,
        SEL_TMR  = 3'd4
    } rsel_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   stamp;
    } frame_t;

    typedef struct packed {
        code_t  code;
        logic   seen;
        frame_t frm;
    } slot_t;

    // Code after a store: overrun when forced or when the previous content was never read.
    function automatic code_t store_code(code_t cur, logic seen, logic force_ovr);
        if (force_ovr)
            return CODE_OVERRUN;
        if ((cur == CODE_FULL || cur == CODE_OVERRUN) && !seen)
            return CODE_OVERRUN;
        return CODE_FULL;
    endfunction

endpackage

// File: rtl/rxmb_timer.sv
module rxmb_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/rxmb_rdmux.sv
module rxmb_rdmux
    import rxmb_pkg::*;
(
    input  logic [2:0]        sel,
    input  code_t             code,
    input  frame_t            frm,
    input  logic [TS_W-1:0]   tmr,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        case (rsel_e'(sel))
            SEL_CTRL: word = {4'b0, code, 4'b0, frm.dlc, frm.stamp};
            SEL_ID:   word = {{(WORD_W-ID_W){1'b0}}, frm.id};
            SEL_DHI:  word = frm.data[DATA_W-1:WORD_W];
            SEL_DLO:  word = frm.data[WORD_W-1:0];
            SEL_TMR:  word = {{(WORD_W-TS_W){1'b0}}, tmr};
            default:  word = '0;
        endcase
    end
endmodule

// File: rtl/rxmb_lock.sv
module rxmb_lock
    import rxmb_pkg::*;
#(
    parameter  int NUM_BUF = 16,
    localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frm_hit,
    input  logic [IDX_W-1:0] frm_buf,
    input  frame_t           frm_in,
    input  logic             rd_en,
    input  logic [2:0]       rd_sel,
    input  logic [IDX_W-1:0] rd_buf,
    output logic             lock_v,
    output logic [IDX_W-1:0] lock_buf,
    output logic             take,
    output logic             commit_v,
    output frame_t           commit_frm,
    output logic             commit_ovr,
    output logic             stage_v
);
    typedef struct packed {
        logic             lock_v;
        logic [IDX_W-1:0] lock_buf;
        logic             stg_v;
        logic             stg_ovr;
        frame_t           stg;
    } lk_t;

    lk_t    d, q;
    logic   release_w, eff_v, eff_ovr;
    frame_t eff_frm;

    always_comb begin
        d         = q;
        take      = frm_hit && q.lock_v && (frm_buf == q.lock_buf);
        release_w = q.lock_v && rd_en &&
                    ((rsel_e'(rd_sel) == SEL_TMR) ||
                     ((rsel_e'(rd_sel) == SEL_CTRL) && (rd_buf != q.lock_buf)));
        // A frame arriving at the frozen slot replaces any parked one.
        eff_v   = take | q.stg_v;
        eff_frm = take ? frm_in : q.stg;
        eff_ovr = take ? q.stg_v : q.stg_ovr;

        commit_v   = release_w && eff_v;
        commit_frm = eff_frm;
        commit_ovr = eff_ovr;

        if (release_w) begin
            d.stg_v   = 1'b0;
            d.stg_ovr = 1'b0;
        end else begin
            d.stg_v   = eff_v;
            d.stg_ovr = eff_ovr;
            d.stg     = eff_frm;
        end

        if (rd_en && rsel_e'(rd_sel) == SEL_CTRL) begin
            d.lock_v   = 1'b1;
            d.lock_buf = rd_buf;
        end else if (rd_en && rsel_e'(rd_sel) == SEL_TMR) begin
            d.lock_v   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lock_v   = q.lock_v;
    assign lock_buf = q.lock_buf;
    assign stage_v  = q.stg_v;
endmodule

// File: rtl/rx_buffer_mgr.sv
module rx_buffer_mgr
    import rxmb_pkg::*;
#(
    parameter  int NUM_BUF = 16,
    localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_buf,
    input  logic [3:0]         cfg_code,
    input  logic               frm_valid,
    input  logic [IDX_W-1:0]   frm_buf,
    input  logic [28:0]        frm_id,
    input  logic [3:0]         frm_dlc,
    input  logic [63:0]        frm_data,
    input  logic               rd_en,
    input  logic [2:0]         rd_sel,
    input  logic [IDX_W-1:0]   rd_buf,
    output logic [31:0]        rd_data,
    input  logic               flag_clr_we,
    input  logic [NUM_BUF-1:0] flag_clr,
    output logic [NUM_BUF-1:0] flags,
    output logic [15:0]        timer
);
    typedef struct packed {
        slot_t [NUM_BUF-1:0] slots;
        logic  [NUM_BUF-1:0] flg;
        logic  [WORD_W-1:0]  rdw;
    } state_t;

    state_t d, q;

    logic [TS_W-1:0]   tmr;
    logic [WORD_W-1:0] rd_word;
    logic              frm_hit, take, commit_v, commit_ovr, lock_v, stage_v;
    logic [IDX_W-1:0]  lock_buf;
    frame_t            frm_now, commit_frm, locked_frm;
    logic              direct_en, commit_en;

    rxmb_timer #(.W(TS_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tmr)
    );

    assign frm_now = '{id: frm_id, dlc: frm_dlc, data: frm_data, stamp: tmr};
    assign frm_hit = frm_valid && (q.slots[frm_buf].code != CODE_INACTIVE);

    rxmb_lock #(.NUM_BUF(NUM_BUF)) i_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_hit    (frm_hit),
        .frm_buf    (frm_buf),
        .frm_in     (frm_now),
        .rd_en      (rd_en),
        .rd_sel     (rd_sel),
        .rd_buf     (rd_buf),
        .lock_v     (lock_v),
        .lock_buf   (lock_buf),
        .take       (take),
        .commit_v   (commit_v),
        .commit_frm (commit_frm),
        .commit_ovr (commit_ovr),
        .stage_v    (stage_v)
    );

    rxmb_rdmux i_rdmux (
        .sel  (rd_sel),
        .code (q.slots[rd_buf].code),
        .frm  (q.slots[rd_buf].frm),
        .tmr  (tmr),
        .word (rd_word)
    );

    always_comb begin
        d = q;

        direct_en = frm_hit && !take && !(cfg_we && cfg_buf == frm_buf);
        commit_en = commit_v && !(cfg_we && cfg_buf == lock_buf);

        if (flag_clr_we)
            d.flg = q.flg & ~flag_clr;

        if (rd_en)
            d.rdw = rd_word;
        if (rd_en && rsel_e'(rd_sel) == SEL_CTRL)
            d.slots[rd_buf].seen = 1'b1;

        if (commit_en) begin
            d.slots[lock_buf].code = store_code(q.slots[lock_buf].code,
                                                q.slots[lock_buf].seen, commit_ovr);
            d.slots[lock_buf].frm  = commit_frm;
            d.slots[lock_buf].seen = 1'b0;
            d.flg[lock_buf]        = 1'b1;
        end

        if (direct_en) begin
            d.slots[frm_buf].code = store_code(q.slots[frm_buf].code,
                                               q.slots[frm_buf].seen, 1'b0);
            d.slots[frm_buf].frm  = frm_now;
            d.slots[frm_buf].seen = 1'b0;
            d.flg[frm_buf]        = 1'b1;
        end

        if (cfg_we) begin
            d.slots[cfg_buf].code = cfg_code;
            d.slots[cfg_buf].seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign locked_frm = q.slots[lock_buf].frm;
    assign rd_data    = q.rdw;
    assign flags      = q.flg;
    assign timer      = tmr;
endmodule

// File: rtl/rxmb_checker.sv
module rxmb_checker
    import rxmb_pkg::*;
#(
    parameter  int NUM_BUF = 16,
    localparam int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [2:0]       rd_sel,
    input logic [IDX_W-1:0] rd_buf,
    input logic             lock_v,
    input logic [IDX_W-1:0] lock_buf,
    input logic             stage_v,
    input frame_t           locked_frm,
    input logic [15:0]      timer
);
    // R4: a control-word read freezes the addressed slot from the next cycle
    a_r4_ctrl_read_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 3'd0) |=> (lock_v && lock_buf == $past(rd_buf)));

    // R4: frozen content never changes while the same slot stays frozen
    a_r4_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_v && $past(lock_v) && lock_buf == $past(lock_buf)) |-> $stable(locked_frm));

    // R5: a timer read ends the freeze
    a_r5_timer_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == 3'd4) |=> !lock_v);

    // R8: a parked frame only exists while a slot is frozen
    a_r8_stage_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        stage_v |-> lock_v);

    // R9: the timer steps by one each cycle
    a_r9_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (timer == 16'($past(timer) + 16'd1)));
endmodule

bind rx_buffer_mgr rxmb_checker #(.NUM_BUF(NUM_BUF)) i_rxmb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .rd_buf     (rd_buf),
    .lock_v     (lock_v),
    .lock_buf   (lock_buf),
    .stage_v    (stage_v),
    .locked_frm (locked_frm),
    .timer      (timer)
);

// File: tb/test_rx_buffer_mgr.sv
module test_rx_buffer_mgr;
    localparam int  NB      = 16;
    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_buf = 0;
    logic [3:0]  cfg_code = 0;
    logic        frm_valid = 0;
    logic [3:0]  frm_buf = 0;
    logic [28:0] frm_id = 0;
    logic [3:0]  frm_dlc = 0;
    logic [63:0] frm_data = 0;
    logic        rd_en = 0;
    logic [2:0]  rd_sel = 0;
    logic [3:0]  rd_buf = 0;
    logic [31:0] rd_data;
    logic        flag_clr_we = 0;
    logic [NB-1:0] flag_clr = 0;
    logic [NB-1:0] flags;
    logic [15:0] timer;

    always #(CLK_PER/2) clk = ~clk;

    rx_buffer_mgr #(.NUM_BUF(NB)) i_rx_buffer_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_buf(cfg_buf), .cfg_code(cfg_code),
        .frm_valid(frm_valid), .frm_buf(frm_buf), .frm_id(frm_id), .frm_dlc(frm_dlc),
        .frm_data(frm_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_buf(rd_buf),
        .rd_data(rd_data), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
        .flags(flags), .timer(timer)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string tag    = "R1";

    // ---------------- behavioural reference model ----------------
    int          m_code  [NB];
    bit          m_seen  [NB];
    int          m_id    [NB];
    int          m_dlc   [NB];
    logic [63:0] m_data  [NB];
    int          m_stamp [NB];
    logic [NB-1:0] m_flg;
    logic [31:0] m_rd;
    int          m_tmr;
    bit          m_lv, m_sv, m_sovr;
    int          m_lb, s_id, s_dlc, s_stamp;
    logic [63:0] s_data;

    function automatic int after_store(int cur, bit seen, bit ovr);
        if (ovr) return 6;
        if ((cur == 2 || cur == 6) && !seen) return 6;
        return 2;
    endfunction

    function automatic logic [31:0] m_word(int sel, int b);
        case (sel)
            0: return (32'(m_code[b]) << 24) | (32'(m_dlc[b]) << 16) | 32'(m_stamp[b]);
            1: return 32'(m_id[b]);
            2: return m_data[b][63:32];
            3: return m_data[b][31:0];
            4: return 32'(m_tmr);
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                m_code[i] = 0; m_seen[i] = 0; m_id[i] = 0; m_dlc[i] = 0;
                m_data[i] = 0; m_stamp[i] = 0;
            end
            m_flg = 0; m_rd = 0; m_tmr = 0; m_lv = 0; m_sv = 0; m_sovr = 0; m_lb = 0;
            s_id = 0; s_dlc = 0; s_data = 0; s_stamp = 0;
        end else begin
            bit tk, dir, rel, ev, eovr, cm;
            int fb, rb, sel, ccode, dcode;
            int e_id, e_dlc, e_stamp;
            logic [63:0] e_data;
            fb = frm_buf; rb = rd_buf; sel = rd_sel;
            if (rd_en) m_rd = m_word(sel, rb);
            tk  = frm_valid && m_code[fb] != 0 && m_lv && fb == m_lb;
            dir = frm_valid && m_code[fb] != 0 && !tk && !(cfg_we && cfg_buf == fb);
            rel = m_lv && rd_en && (sel == 4 || (sel == 0 && rb != m_lb));
            if (tk) begin
                ev = 1; eovr = m_sv;
                e_id = frm_id; e_dlc = frm_dlc; e_data = frm_data; e_stamp = m_tmr;
            end else begin
                ev = m_sv; eovr = m_sovr;
                e_id = s_id; e_dlc = s_dlc; e_data = s_data; e_stamp = s_stamp;
            end
            cm = rel && ev && !(cfg_we && cfg_buf == m_lb);
            ccode = after_store(m_code[m_lb], m_seen[m_lb], eovr);
            dcode = after_store(m_code[fb], m_seen[fb], 0);
            if (flag_clr_we) m_flg = m_flg & ~flag_clr;
            if (rd_en && sel == 0) m_seen[rb] = 1;
            if (cm) begin
                m_code[m_lb] = ccode; m_id[m_lb] = e_id; m_dlc[m_lb] = e_dlc;
                m_data[m_lb] = e_data; m_stamp[m_lb] = e_stamp; m_seen[m_lb] = 0;
                m_flg[m_lb] = 1;
            end
            if (dir) begin
                m_code[fb] = dcode; m_id[fb] = frm_id; m_dlc[fb] = frm_dlc;
                m_data[fb] = frm_data; m_stamp[fb] = m_tmr; m_seen[fb] = 0;
                m_flg[fb] = 1;
            end
            if (cfg_we) begin
                m_code[cfg_buf] = cfg_code; m_seen[cfg_buf] = 0;
            end
            if (rel) begin
                m_sv = 0; m_sovr = 0;
            end else begin
                m_sv = ev; m_sovr = eovr;
                s_id = e_id; s_dlc = e_dlc; s_data = e_data; s_stamp = e_stamp;
            end
            if (rd_en && sel == 0) begin
                m_lv = 1; m_lb = rb;
            end else if (rd_en && sel == 4) begin
                m_lv = 0;
            end
            m_tmr = (m_tmr + 1) % 65536;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rd_data !== m_rd || flags !== m_flg || timer !== 16'(m_tmr)) begin
                errors++;
                $display("FAIL %s model: rd_data %h exp %h flags %h exp %h timer %h exp %h",
                         tag, rd_data, m_rd, flags, m_flg, timer, 16'(m_tmr));
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic rd(input int sel, input int b, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1; rd_sel = 3'(sel); rd_buf = 4'(b);
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    task automatic send(input int b, input int id, input logic [63:0] dat);
        @(negedge clk);
        frm_valid = 1; frm_buf = 4'(b); frm_id = 29'(id); frm_dlc = 4'd8; frm_data = dat;
        @(negedge clk);
        frm_valid = 0;
    endtask

    task automatic cfg(input int b, input int code);
        @(negedge clk);
        cfg_we = 1; cfg_buf = 4'(b); cfg_code = 4'(code);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in phase %s", tag);
        finish_run();
    end

    initial begin
        logic [31:0] v, t1, t2;

        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 flags after reset", 64'(flags), 0);
        chk("R1 rd_data after reset", 64'(rd_data), 0);
        chk("R1 timer after reset", 64'(timer), 0);
        rst_n = 1;
        rd(0, 0, v);  chk("R1 slot 0 code inactive", 64'(v[27:24]), 0);
        rd(4, 0, v);

        tag = "R2";
        send(1, 29'h123, 64'h1111);
        chk("R2 inactive slot sets no flag", 64'(flags), 0);
        rd(0, 1, v);  chk("R2 inactive slot keeps code", 64'(v[27:24]), 0);
        rd(4, 0, v);
        for (int i = 0; i < 4; i++) cfg(i, 4);
        rd(0, 2, v);  chk("R2 configured code empty", 64'(v[27:24]), 4);
        rd(4, 0, v);

        tag = "R3";
        send(0, 29'h1ABCDEF, 64'hDEADBEEF_01234567);
        chk("R3 flag set on store", 64'(flags[0]), 1);
        rd(0, 0, v);  chk("R3 code full", 64'(v[27:24]), 2);
        chk("R11 dlc field", 64'(v[19:16]), 8);
        rd(1, 0, v);  chk("R11 id word", 64'(v), 64'h1ABCDEF);
        rd(2, 0, v);  chk("R11 data high word", 64'(v), 64'hDEADBEEF);
        rd(3, 0, v);  chk("R11 data low word", 64'(v), 64'h01234567);
        rd(4, 0, v);

        tag = "R6";
        send(0, 29'h55, 64'h2);
        rd(0, 0, v);  chk("R6 read slot stays full", 64'(v[27:24]), 2);
        rd(4, 0, v);

        tag = "R7";
        send(1, 29'h71, 64'h71);
        send(1, 29'h72, 64'h72);
        rd(0, 1, v);  chk("R7 unread overwrite gives overrun", 64'(v[27:24]), 6);
        rd(1, 1, v);  chk("R7 new content kept", 64'(v), 64'h72);
        rd(4, 0, v);

        tag = "R8";
        rd(0, 2, v);  chk("R4 empty slot before freeze", 64'(v[27:24]), 4);
        send(2, 29'h81, 64'h81);
        rd(0, 2, v);  chk("R5 same-slot read keeps freeze", 64'(v[27:24]), 4);
        rd(1, 2, v);  chk("R4 frozen slot id unchanged", 64'(v), 0);
        rd(4, 0, v);
        rd(0, 2, v);  chk("R8 parked frame committed full", 64'(v[27:24]), 2);
        chk("R8 flag after commit", 64'(flags[2]), 1);
        rd(1, 2, v);  chk("R8 parked id", 64'(v), 64'h81);
        rd(0, 3, v);
        send(3, 29'h91, 64'h91);
        send(3, 29'h92, 64'h92);
        rd(0, 0, v);
        rd(0, 3, v);  chk("R8 twice parked gives overrun", 64'(v[27:24]), 6);
        rd(1, 3, v);  chk("R8 latest parked frame wins", 64'(v), 64'h92);
        rd(4, 0, v);

        tag = "R9";
        rd(4, 0, t1);
        repeat (5) @(negedge clk);
        rd(4, 0, t2);
        chk("R9 timer read distance", 64'(16'(t2 - t1)), 7);
        rd(4, 0, t1);
        repeat (65536) @(negedge clk);
        rd(4, 0, t2);
        chk("R9 timer wraps", 64'(16'(t2 - t1)), 2);

        tag = "R10";
        @(negedge clk);
        flag_clr_we = 1; flag_clr = '1;
        @(negedge clk);
        flag_clr_we = 0;
        chk("R10 write-one clears flags", 64'(flags), 0);
        @(negedge clk);
        flag_clr_we = 1; flag_clr = '1;
        frm_valid = 1; frm_buf = 0; frm_id = 29'h5; frm_data = 64'h5;
        @(negedge clk);
        flag_clr_we = 0; frm_valid = 0;
        chk("R10 store wins over clear", 64'(flags), 1);

        tag = "R5";
        for (int i = 0; i < NB; i++) cfg(i, 4);
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            cfg_we    = ($urandom % 16) == 0;
            cfg_buf   = 4'($urandom % NB);
            cfg_code  = ($urandom % 4 == 0) ? 4'd0 : 4'd4;
            frm_valid = ($urandom % 3) == 0;
            frm_buf   = 4'($urandom % 4);
            frm_id    = 29'($urandom);
            frm_dlc   = 4'($urandom % 9);
            frm_data  = {$urandom, $urandom};
            rd_en     = ($urandom % 2) == 0;
            rd_sel    = 3'($urandom % 5);
            rd_buf    = 4'($urandom % 4);
            flag_clr_we = ($urandom % 8) == 0;
            flag_clr  = NB'($urandom);
        end
        @(negedge clk);
        cfg_we = 0; frm_valid = 0; rd_en = 0; flag_clr_we = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule